// File: doc/BRIEF.md
# FP32 four-lane dot-product unit

This unit takes two 128-bit operand vectors, each packed with four IEEE-754 binary32 lanes, and returns their dot product. Each lane pair is multiplied and rounded to binary32 on its own, then the four products are summed in a fixed left-to-right chain, with a rounding after every addition. The scalar result is copied into every 32-bit lane of the 128-bit output word. No fused multiply-add is used anywhere.

A single binary32 multiplier and a single binary32 adder, both rounding to nearest-even, are shared across several cycles to keep the area small. A per-operation mode bit, captured with the operands, turns on flush-to-zero for denormal products and for a denormal final sum. With the bit clear, the unit handles subnormals in full IEEE fashion. Operands enter through a valid/ready handshake and results leave through another. The unit holds no status, saturation or condition state.

Top module: `dot4_fp32_unit`

## Requirements
- R1: Lane i of an operand is bits [32*i+31 : 32*i], so lane 0 is the lowest 32 bits. The result is the sum over i of a[i]*b[i].
- R2: Each product a[i]*b[i] is rounded to binary32 (round to nearest, ties to even) before it enters any addition; there is no fusion.
- R3: Products are added as ((p0 + p1) + p2) + p3, which is exactly three additions, each rounded to nearest-even.
- R4: With the flush bit set, a product with exponent field 0 and a nonzero fraction is replaced by a zero of the same sign before it enters the sum.
- R5: With the flush bit set, a final sum with exponent field 0 and a nonzero fraction is replaced by a zero of the same sign.
- R6: With the flush bit clear, subnormal products and sums pass through unchanged and are rounded per IEEE-754.
- R7: All four 32-bit lanes of out_data carry the same scalar result.
- R8: A NaN operand, infinity times zero, or the sum of opposite infinities produces the quiet NaN 0x7FC00000.
- R9: A product or sum too large for binary32 becomes an infinity with the correct sign (0x7F800000 or 0xFF800000). An exact cancellation gives +0 (0x00000000).
- R10: in_ready is high only while idle. A beat is taken on a cycle with in_valid and in_ready both high. While busy, in_valid is ignored. out_valid stays high with stable out_data until out_ready is seen, and the unit then returns to idle.
- R11: After reset, in_ready is high and out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Unit is idle and takes an operand pair |
| in_a | input | 128 | First operand, four binary32 lanes |
| in_b | input | 128 | Second operand, four binary32 lanes |
| in_ftz | input | 1 | Flush-to-zero mode for this operation |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Dot product copied into all four lanes |

## Verification
The bench builds the unit with its default of four lanes. This gives a chain of three roundings, so a reordered or fused sum shows up as a different bit pattern in directed cases built on ties and cancellations. Random operands are drawn from three pools: ordinary exponents, very small exponents whose products fall into the subnormal range, and raw bit patterns that include infinities and NaNs. Each pool is run with the flush bit both set and clear. Results are compared against an exact-integer rounding model, and the output side is stalled at random to exercise holding of the result.

// File: rtl/dot4_pkg.sv
// Shared constants, state type and the flush helper for the dot-product unit.
// Assumes binary32 operands throughout.
package dot4_pkg;
    localparam int FP_W = 32;
    localparam logic [FP_W-1:0] QNAN = 32'h7FC0_0000;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_t;

    // Replace a subnormal with a same-signed zero when enabled.
    function automatic logic [FP_W-1:0] ftz32(input logic [FP_W-1:0] x, input logic en);
        if (en && x[30:23] == 8'd0)
            return {x[31], 31'd0};
        return x;
    endfunction
endpackage

// File: rtl/fp32_mul.sv
// Combinational binary32 multiplier, round to nearest-even, full subnormal
// support. Any NaN or infinity-times-zero yields the default quiet NaN.
// Assumes nothing about operand classes.
module fp32_mul
    import dot4_pkg::*;
(
    input  logic [FP_W-1:0] op_a,
    input  logic [FP_W-1:0] op_b,
    output logic [FP_W-1:0] prod
);
    logic        sgn, nan_in, inf_a, inf_b, zero_a, zero_b, normal, ovf;
    logic        guard, sticky, inc;
    logic [23:0] fa, fb;
    logic [47:0] m;
    logic [63:0] mm;
    logic [22:0] sig;
    logic [7:0]  efield;
    logic [30:0] packed_v;
    int          lead, sh, ea_e, eb_e, bexp;

    // Multiply, normalise, round and classify in one combinational pass.
    always_comb begin
        sgn    = op_a[31] ^ op_b[31];
        nan_in = (&op_a[30:23] && |op_a[22:0]) || (&op_b[30:23] && |op_b[22:0]);
        inf_a  = &op_a[30:23] && ~|op_a[22:0];
        inf_b  = &op_b[30:23] && ~|op_b[22:0];
        zero_a = ~|op_a[30:0];
        zero_b = ~|op_b[30:0];
        fa     = {|op_a[30:23], op_a[22:0]};
        fb     = {|op_b[30:23], op_b[22:0]};
        ea_e   = (op_a[30:23] == 8'd0) ? 1 : int'(op_a[30:23]);
        eb_e   = (op_b[30:23] == 8'd0) ? 1 : int'(op_b[30:23]);
        m      = fa * fb;
        mm     = {16'd0, m};
        lead   = 0;
        for (int i = 0; i < 48; i++)
            if (m[i]) lead = i;
        bexp   = lead + ea_e + eb_e - 173;
        normal = (lead - 23) >= (151 - ea_e - eb_e);
        sh     = normal ? (lead - 23) : (151 - ea_e - eb_e);
        ovf    = normal && (bexp >= 255);
        efield = normal ? 8'(bexp) : 8'd0;
        if (sh > 0) begin
            if (sh > 49) sh = 49;
            sig    = 23'(mm >> sh);
            guard  = |(mm & (64'd1 << (sh - 1)));
            sticky = |(mm & ((64'd1 << (sh - 1)) - 64'd1));
        end else begin
            sig    = 23'(mm << (-sh));
            guard  = 1'b0;
            sticky = 1'b0;
        end
        inc      = guard & (sticky | sig[0]);
        packed_v = {efield, sig} + {30'd0, inc};
        if (nan_in || (inf_a && zero_b) || (inf_b && zero_a))
            prod = QNAN;
        else if (inf_a || inf_b || ovf)
            prod = {sgn, 8'hFF, 23'd0};
        else if (zero_a || zero_b)
            prod = {sgn, 31'd0};
        else
            prod = {sgn, packed_v};
    end
endmodule

// File: rtl/fp32_add.sv
// Combinational binary32 adder, round to nearest-even with guard, round and
// sticky bits; subnormal results kept. Exact cancellation gives +0.
// Assumes nothing about operand classes.
module fp32_add
    import dot4_pkg::*;
(
    input  logic [FP_W-1:0] op_a,
    input  logic [FP_W-1:0] op_b,
    output logic [FP_W-1:0] sum
);
    logic            swap, nan_in, inf_a, inf_b, inc;
    logic [FP_W-1:0] big, sml;
    logic [26:0]     ab, bb, bs;
    logic [27:0]     r;
    logic [7:0]      efield;
    logic [30:0]     packed_v;
    int              eb_e, es_e, d, e;

    // Align the smaller operand, add or subtract, normalise and round.
    always_comb begin
        nan_in = (&op_a[30:23] && |op_a[22:0]) || (&op_b[30:23] && |op_b[22:0]);
        inf_a  = &op_a[30:23] && ~|op_a[22:0];
        inf_b  = &op_b[30:23] && ~|op_b[22:0];
        swap   = op_b[30:0] > op_a[30:0];
        big    = swap ? op_b : op_a;
        sml    = swap ? op_a : op_b;
        eb_e   = (big[30:23] == 8'd0) ? 1 : int'(big[30:23]);
        es_e   = (sml[30:23] == 8'd0) ? 1 : int'(sml[30:23]);
        ab     = {|big[30:23], big[22:0], 3'd0};
        bb     = {|sml[30:23], sml[22:0], 3'd0};
        d      = eb_e - es_e;
        if (d >= 27) begin
            bs = {26'd0, |bb};
        end else begin
            bs = bb >> d;
            if ((bb & ((27'd1 << d) - 27'd1)) != 27'd0) bs[0] = 1'b1;
        end
        r = (big[31] == sml[31]) ? ({1'b0, ab} + {1'b0, bs}) : ({1'b0, ab} - {1'b0, bs});
        e = eb_e;
        if (r[27]) begin
            r = {1'b0, r[27:1]} | {27'd0, r[0]};
            e = e + 1;
        end
        for (int i = 0; i < 26; i++) begin
            if (!r[26] && r != 28'd0 && e > 1) begin
                r = r << 1;
                e = e - 1;
            end
        end
        efield   = r[26] ? 8'(e) : 8'd0;
        inc      = r[2] & (r[1] | r[0] | r[3]);
        packed_v = {efield, r[25:3]} + {30'd0, inc};
        if (nan_in || (inf_a && inf_b && (op_a[31] != op_b[31])))
            sum = QNAN;
        else if (inf_a)
            sum = op_a;
        else if (inf_b)
            sum = op_b;
        else if (~|op_a[30:0] && ~|op_b[30:0])
            sum = {op_a[31] & op_b[31], 31'd0};
        else if (r == 28'd0)
            sum = 32'd0;
        else if (e >= 255)
            sum = {big[31], 8'hFF, 23'd0};
        else
            sum = {big[31], packed_v};
    end
endmodule

// File: rtl/dot4_fp32_unit.sv
// Sequential binary32 dot product over LANES lanes with one shared multiplier
// and one shared adder. Step k registers product k while the adder folds the
// previous product into the running sum; the last step rounds, optionally
// flushes, and parks the scalar for broadcast. Assumes LANES >= 2.
module dot4_fp32_unit
    import dot4_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [LANES*FP_W-1:0] in_a,
    input  logic [LANES*FP_W-1:0] in_b,
    input  logic                  in_ftz,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [LANES*FP_W-1:0] out_data
);
    localparam int STEP_W = $clog2(LANES + 1);
    localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [STEP_W-1:0] LAST = STEP_W'(LANES);

    state_t            state_q;
    logic [STEP_W-1:0] step_q;
    logic [FP_W-1:0]   a_q [LANES];
    logic [FP_W-1:0]   b_q [LANES];
    logic              mode_q;
    logic [FP_W-1:0]   prod_q, acc_q, res_q;
    logic [IDX_W-1:0]  lane_sel;
    logic [FP_W-1:0]   mul_p, add_s;
    logic              take;

    assign in_ready = (state_q == ST_IDLE);
    assign out_valid = (state_q == ST_DONE);
    assign take = in_valid && in_ready;
    assign lane_sel = (step_q < LAST) ? step_q[IDX_W-1:0] : '0;

    fp32_mul u_mul (.op_a(a_q[lane_sel]), .op_b(b_q[lane_sel]), .prod(mul_p));
    fp32_add u_add (.op_a(acc_q), .op_b(prod_q), .sum(add_s));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Capture operand lane g when a new pair is taken.
        always_ff @(posedge clk) begin
            if (take) begin
                a_q[g] <= in_a[g*FP_W +: FP_W];
                b_q[g] <= in_b[g*FP_W +: FP_W];
            end
        end
        assign out_data[g*FP_W +: FP_W] = res_q;
    end

    // Sequence the multiply/accumulate steps and the output handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            mode_q  <= 1'b0;
            prod_q  <= '0;
            acc_q   <= '0;
            res_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        state_q <= ST_RUN;
                        step_q  <= '0;
                        mode_q  <= in_ftz;
                    end
                end
                ST_RUN: begin
                    if (step_q < LAST)
                        prod_q <= ftz32(mul_p, mode_q);
                    if (step_q == STEP_W'(1))
                        acc_q <= prod_q;
                    else if (step_q >= STEP_W'(2))
                        acc_q <= add_s;
                    if (step_q == LAST) begin
                        res_q   <= ftz32(add_s, mode_q);
                        state_q <= ST_DONE;
                    end
                    step_q <= step_q + STEP_W'(1);
                end
                ST_DONE: begin
                    if (out_ready)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dot4_fp32_checker.sv
// Protocol and result-format properties for the dot-product unit, attached
// with a bind. Assumes mode_q holds the flush bit of the pending result.
module dot4_fp32_checker #(
    parameter int LANES = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_ready,
    input logic                  out_valid,
    input logic                  out_ready,
    input logic [LANES*32-1:0]   out_data,
    input logic                  mode_q
);
    p_splat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_data == {LANES{out_data[31:0]}});

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_no_subnormal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && mode_q |-> !(out_data[30:23] == 8'd0 && out_data[22:0] != 23'd0));

    p_quiet_nan_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (&out_data[30:23]) && (|out_data[22:0]) |-> out_data[31:0] == 32'h7FC0_0000);
endmodule

bind dot4_fp32_unit dot4_fp32_checker #(.LANES(LANES)) u_check (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .mode_q(mode_q)
);

// File: tb/tb_dot4_fp32_unit.sv
module tb_dot4_fp32_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_a = '0;
    logic [127:0] in_b = '0;
    logic         in_ftz = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [127:0] out_data;
    int           n_chk = 0;
    int           n_bad = 0;

    always #4 clk = ~clk;

    dot4_fp32_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_ftz(in_ftz), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // ---- reference model: exact integer value, then one rounding ----
    function automatic logic [31:0] rnd(input logic s, input logic [299:0] mag, input int lsb);
        logic [299:0] one, sig;
        int h, q, sh;
        logic half, rest;
        one = 300'd1;
        h = -1;
        for (int i = 0; i < 300; i++) if (mag[i]) h = i;
        if (h < 0) return {s, 31'd0};
        q = h + lsb - 23;
        if (q < -149) q = -149;
        sh = q - lsb;
        if (sh <= 0) sig = mag << (-sh);
        else begin
            sig  = mag >> sh;
            half = mag[sh-1];
            rest = (mag & ((one << (sh - 1)) - one)) != '0;
            if (half && (rest || sig[0])) sig = sig + one;
        end
        if (sig == (one << 24)) begin
            sig = sig >> 1;
            q++;
        end
        if (sig[23]) begin
            if (q + 150 >= 255) return {s, 8'hFF, 23'd0};
            return {s, 8'(q + 150), sig[22:0]};
        end
        return {s, 8'd0, sig[22:0]};
    endfunction

    function automatic bit is_nan(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction
    function automatic bit is_inf(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] == 0);
    endfunction
    function automatic bit is_zero(input logic [31:0] x);
        return x[30:0] == 0;
    endfunction
    function automatic int eff_exp(input logic [31:0] x);
        return (x[30:23] == 0) ? 1 : int'(x[30:23]);
    endfunction
    function automatic logic [299:0] signif(input logic [31:0] x);
        return 300'({(x[30:23] != 0), x[22:0]});
    endfunction

    function automatic logic [31:0] mul_ref(input logic [31:0] a, input logic [31:0] b);
        logic s;
        s = a[31] ^ b[31];
        if (is_nan(a) || is_nan(b)) return 32'h7FC00000;
        if ((is_inf(a) && is_zero(b)) || (is_inf(b) && is_zero(a))) return 32'h7FC00000;
        if (is_inf(a) || is_inf(b)) return {s, 8'hFF, 23'd0};
        if (is_zero(a) || is_zero(b)) return {s, 31'd0};
        return rnd(s, signif(a) * signif(b), eff_exp(a) + eff_exp(b) - 300);
    endfunction

    function automatic logic [31:0] add_ref(input logic [31:0] a, input logic [31:0] b);
        logic [299:0] ma, mb, mag;
        logic s;
        if (is_nan(a) || is_nan(b)) return 32'h7FC00000;
        if (is_inf(a) && is_inf(b)) return (a[31] == b[31]) ? a : 32'h7FC00000;
        if (is_inf(a)) return a;
        if (is_inf(b)) return b;
        if (is_zero(a) && is_zero(b)) return {a[31] & b[31], 31'd0};
        ma = signif(a) << (eff_exp(a) - 1);
        mb = signif(b) << (eff_exp(b) - 1);
        if (a[31] == b[31]) begin mag = ma + mb; s = a[31]; end
        else if (ma >= mb) begin mag = ma - mb; s = a[31]; end
        else begin mag = mb - ma; s = b[31]; end
        if (mag == '0) return 32'd0;
        return rnd(s, mag, -149);
    endfunction

    function automatic logic [31:0] flush(input logic [31:0] x, input logic en);
        return (en && x[30:23] == 0) ? {x[31], 31'd0} : x;
    endfunction

    function automatic logic [31:0] dot_ref(input logic [127:0] a, input logic [127:0] b, input logic f);
        logic [31:0] acc, p;
        acc = 32'd0;
        for (int i = 0; i < 4; i++) begin
            p = flush(mul_ref(a[i*32 +: 32], b[i*32 +: 32]), f);
            acc = (i == 0) ? p : add_ref(acc, p);
        end
        return flush(acc, f);
    endfunction

    function automatic logic [127:0] pk(input logic [31:0] l0, l1, l2, l3);
        return {l3, l2, l1, l0};
    endfunction

    function automatic logic [31:0] rand_f(input int unsigned kind);
        logic [31:0] r;
        r = $urandom;
        case (kind)
            0: return {r[31], 8'($urandom_range(110, 144)), r[22:0]};
            1: return {r[31], 8'($urandom_range(52, 72)), r[22:0]};
            2: return r;
            default: begin
                case ($urandom_range(0, 6))
                    0: return 32'h00000000;
                    1: return 32'h80000000;
                    2: return 32'h7F800000;
                    3: return 32'hFF800000;
                    4: return 32'h7F812345;
                    5: return {r[31], 8'd0, r[22:0]};
                    default: return {r[31], 31'h7F7FFFFF};
                endcase
            end
        endcase
    endfunction

    // One full transaction; optionally stalls the output and offers junk while busy.
    task automatic run_op(input logic [127:0] a, input logic [127:0] b, input logic f,
                          input int stall, input bit junk, input string rq,
                          input bit use_k, input logic [31:0] k);
        logic [31:0]  e;
        logic [127:0] first;
        e = dot_ref(a, b, f);
        if (use_k) check(e == k, rq, "model self-check", {96'd0, e}, {96'd0, k});
        @(negedge clk);
        check(in_ready == 1'b1, "R10", "idle before accept", {127'd0, in_ready}, 128'd1);
        in_a = a; in_b = b; in_ftz = f; in_valid = 1'b1;
        @(negedge clk);
        if (junk) begin
            in_a = ~a; in_b = b ^ 128'h1234; in_ftz = ~f;
        end else in_valid = 1'b0;
        check(in_ready == 1'b0, "R10", "busy after accept", {127'd0, in_ready}, 128'd0);
        while (!out_valid) begin
            @(negedge clk);
            if (!out_valid && in_ready) begin
                check(1'b0, "R10", "idle before result", 128'd1, 128'd0);
                break;
            end
        end
        in_valid = 1'b0;
        first = out_data;
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            check(out_valid && out_data == first, "R10", "hold under stall",
                  out_data, first);
        end
        check(out_data == {4{e}}, rq, "result broadcast (R7)", out_data, {4{e}});
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check(!out_valid && in_ready, "R10", "release after out_ready",
              {126'd0, out_valid, in_ready}, 128'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog actual=hung expected=complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] ra, rb;
        int unsigned  kind;
        void'($urandom(32'd20240613));
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1 && out_valid == 1'b0, "R11", "held in reset",
              {126'd0, in_ready, out_valid}, 128'd2);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1 && out_valid == 1'b0, "R11", "after reset",
              {126'd0, in_ready, out_valid}, 128'd2);

        // R1 lane mapping and a plain dot product
        run_op(pk(32'h40000000, 0, 0, 0), pk(32'h40400000, 32'h40A00000, 32'h40E00000, 32'h41100000),
               1'b0, 0, 1'b0, "R1", 1'b1, 32'h40C00000);
        run_op(pk(32'h3F800000, 32'h40000000, 32'h40400000, 32'h40800000),
               pk(32'h40A00000, 32'h40C00000, 32'h40E00000, 32'h41000000),
               1'b0, 2, 1'b0, "R1", 1'b1, 32'h428C0000);
        // R2 separate product rounding (a fused form would give 2^-24)
        run_op(pk(32'h3F800800, 32'h3F801000, 0, 0), pk(32'h3F800800, 32'hBF800000, 0, 0),
               1'b0, 0, 1'b0, "R2", 1'b1, 32'h00000000);
        // R3 left-to-right chain with tie-to-even after each add
        run_op(pk(32'h4B800000, 32'h3F800000, 32'h3F800000, 32'h4B800000),
               pk(32'h3F800000, 32'h3F800000, 32'h3F800000, 32'hBF800000),
               1'b0, 1, 1'b0, "R3", 1'b1, 32'h00000000);
        // R4 / R6 subnormal product, flushed vs kept, with sign
        run_op(pk(32'h9C800000, 32'h80000000, 32'h80000000, 32'h80000000),
               pk(32'h1C800000, 0, 0, 0), 1'b1, 0, 1'b0, "R4", 1'b1, 32'h80000000);
        run_op(pk(32'h9C800000, 32'h80000000, 32'h80000000, 32'h80000000),
               pk(32'h1C800000, 0, 0, 0), 1'b0, 0, 1'b0, "R6", 1'b1, 32'h80000200);
        // R5 / R6 normal products whose sum is subnormal
        run_op(pk(32'h20400000, 32'hA0000000, 0, 0), pk(32'h20000000, 32'h20000000, 0, 0),
               1'b1, 0, 1'b0, "R5", 1'b1, 32'h00000000);
        run_op(pk(32'h20400000, 32'hA0000000, 0, 0), pk(32'h20000000, 32'h20000000, 0, 0),
               1'b0, 0, 1'b0, "R6", 1'b1, 32'h00400000);
        // R8 invalid cases
        run_op(pk(32'h7FA00000, 0, 0, 0), pk(32'h3F800000, 0, 0, 0),
               1'b0, 0, 1'b0, "R8", 1'b1, 32'h7FC00000);
        run_op(pk(32'h7F800000, 0, 0, 0), pk(32'h00000000, 0, 0, 0),
               1'b1, 0, 1'b0, "R8", 1'b1, 32'h7FC00000);
        run_op(pk(32'h7F800000, 32'h7F800000, 0, 0), pk(32'h3F800000, 32'hBF800000, 0, 0),
               1'b0, 0, 1'b0, "R8", 1'b1, 32'h7FC00000);
        // R9 overflow in product and in sum
        run_op(pk(32'h71800000, 0, 0, 0), pk(32'h71800000, 0, 0, 0),
               1'b0, 0, 1'b0, "R9", 1'b1, 32'h7F800000);
        run_op(pk(32'h71800000, 0, 0, 0), pk(32'hF1800000, 0, 0, 0),
               1'b0, 0, 1'b0, "R9", 1'b1, 32'hFF800000);
        run_op(pk(32'h7F000000, 32'h7F000000, 0, 0), pk(32'h3F800000, 32'h3F800000, 0, 0),
               1'b0, 0, 1'b0, "R9", 1'b1, 32'h7F800000);
        // R10 new offer while busy is ignored
        run_op(pk(32'h3F800000, 32'h40000000, 32'h40400000, 32'h40800000),
               pk(32'h40A00000, 32'h40C00000, 32'h40E00000, 32'h41000000),
               1'b0, 1, 1'b1, "R10", 1'b1, 32'h428C0000);

        // Random mix: R1 R2 R3 R4 R6 R7 R8 R9 against the reference model
        for (int n = 0; n < 400; n++) begin
            kind = $urandom_range(0, 9);
            for (int l = 0; l < 4; l++) begin
                int unsigned kk;
                kk = (kind < 4) ? 0 : (kind < 7) ? 1 : (kind < 9) ? 2 : 3;
                ra[l*32 +: 32] = rand_f(kk);
                rb[l*32 +: 32] = rand_f(kk);
            end
            run_op(ra, rb, 1'($urandom_range(0, 1)), int'($urandom_range(0, 2)),
                   ($urandom_range(0, 7) == 0), "R3", 1'b0, 32'd0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule